// File: doc/BRIEF.md
# UART Receive Queue with Fill-Level Interrupt

This block buffers characters that a UART receiver has already deserialized until software reads them. A receiver front end offers one entry per cycle, either a data byte with its status bits or a line-break marker. A read strobe from the register interface removes the oldest entry, and the oldest entry is always visible on the read port. The block keeps an empty flag and a full flag. It raises a receive interrupt request when the number of stored entries climbs to a level that software programs.

A configuration bit chooses between two depths. With the bit set, the block is a 16-entry first-in first-out queue. With the bit clear, it holds a single character. Any write that changes this bit discards whatever is stored. The interrupt threshold comes from a separate level register, written through its own strobe. The block decodes bits [5:3] of that register into a threshold of four times their value.

Top module: `uart_rx_queue`

## Requirements
- R1: Entries leave in the order they were accepted. Each entry is 12 bits: data in [7:0] and status in [11:8]. The oldest stored entry is presented on `rd_entry`. Storage is 16 entries in a circular buffer whose read index wraps from the last slot back to the first.
- R2: `in_rdy` is high while the fill count is below 16 in queue mode, and while the fill count is 0 in single mode. An offer made while `in_rdy` is low is dropped without changing any state.
- R3: A `cfg_wr` whose `cfg_fifo_on` differs from the current mode flushes the buffer: count 0, read index 0, empty set, full cleared. A `cfg_wr` that repeats the current mode leaves the contents untouched.
- R4: The interrupt threshold is `(lvl >> 1) & 0x1C`, i.e. four times `lvl[5:3]`. `lvl` is loaded from `lvl_val` on `lvl_wr`.
- R5: `rx_irq` sets when an accepted entry brings the count to the threshold. It clears when a pop brings the count to one below the threshold. Otherwise it holds. Within a cycle the pop is applied before the push.
- R6: `st_empty` clears on every accepted entry. It sets when a pop leaves the count at zero.
- R7: `st_full` sets when an accepted entry brings the count to the mode's capacity (16 or 1). It clears on any `rd_pop` that is not overridden by a configuration write.
- R8: `in_brk` offers the entry 0x400, which is status bit 10 set and data zero. When `in_brk` and `in_vld` are both high, the break entry is stored and the data is not.
- R9: A pop while empty changes no state. The next accepted entry becomes the one presented on `rd_entry`.
- R10: After reset the block is empty, not full, the interrupt is low, single mode is selected, the level register holds 0x12 (threshold 8), and `in_rdy` is high.
- R11: In a cycle with `cfg_wr` high, both the offer and the pop are ignored. `lvl_wr` is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Line-control write strobe |
| cfg_fifo_on | input | 1 | Mode written by cfg_wr: 1 queue, 0 single entry |
| lvl_wr | input | 1 | Level register write strobe |
| lvl_val | input | 6 | Level register write value |
| in_vld | input | 1 | Receiver offers a data entry |
| in_data | input | 8 | Received data byte |
| in_stat | input | 4 | Receiver status bits for the byte |
| in_brk | input | 1 | Receiver reports a line break |
| in_rdy | output | 1 | Block can accept an entry this cycle |
| rd_pop | input | 1 | Data register read strobe, removes oldest entry |
| rd_entry | output | 12 | Oldest stored entry |
| st_empty | output | 1 | No entries stored |
| st_full | output | 1 | Capacity of the current mode reached |
| rx_irq | output | 1 | Receive fill-level interrupt request |

## Verification
A wrong fill count shows up within one cycle in three places: `in_rdy`, `st_empty`, or the cycle in which `rx_irq` changes. A wrong read index or write slot shows up on `rd_entry` at the next pop of the affected entry, which can be up to 16 pops later. For that reason the bench fills and drains the queue across the wrap point and compares `rd_entry` on every cycle that the queue holds data. A missed flush on a mode change shows up at once as stale entries and a clear empty flag.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 8,
  parameter int STAT_W  = 4,
  parameter int LVL_W   = 6,
  parameter int BRK_BIT = 2,
  parameter logic [LVL_W-1:0] LVL_RST = 6'h12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic                     cfg_fifo_on,
  input  logic                     lvl_wr,
  input  logic [LVL_W-1:0]         lvl_val,
  input  logic                     in_vld,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [STAT_W-1:0]        in_stat,
  input  logic                     in_brk,
  output logic                     in_rdy,
  input  logic                     rd_pop,
  output logic [DATA_W+STAT_W-1:0] rd_entry,
  output logic                     st_empty,
  output logic                     st_full,
  output logic                     rx_irq
);
  localparam int EW = DATA_W + STAT_W;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [EW-1:0] BRK_ENTRY = EW'(1) << (DATA_W + BRK_BIT);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr;
  logic [CW-1:0] cnt;
  logic          fifo_on;
  logic [LVL_W-1:0] lvl;

  logic [CW-1:0] cap, cnt_pop, cnt_nxt;
  logic [CW:0]   wsum;
  logic [AW-1:0] wslot, rptr_inc;
  logic [LVL_W-1:0] trig;
  logic          flip, push_ok, pop_ok;
  logic [EW-1:0] in_entry;

  assign cap      = fifo_on ? CW'(DEPTH) : CW'(1);
  assign trig     = (lvl >> 1) & LVL_W'(28);
  assign flip     = cfg_wr && (cfg_fifo_on != fifo_on);
  assign in_rdy   = cnt < cap;
  assign push_ok  = !cfg_wr && (in_vld || in_brk) && in_rdy;
  assign pop_ok   = !cfg_wr && rd_pop && (cnt != '0);
  assign cnt_pop  = cnt - CW'(pop_ok);
  assign cnt_nxt  = cnt_pop + CW'(push_ok);
  assign wsum     = (CW+1)'(rptr) + (CW+1)'(cnt);
  assign wslot    = (wsum >= (CW+1)'(DEPTH)) ? AW'(wsum - (CW+1)'(DEPTH)) : AW'(wsum);
  assign rptr_inc = (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
  assign in_entry = in_brk ? BRK_ENTRY : {in_stat, in_data};
  assign rd_entry = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_ok) begin
      mem[wslot] <= in_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= LVL_RST;
    end else if (lvl_wr) begin
      lvl <= lvl_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on  <= 1'b0;
      rptr     <= '0;
      cnt      <= '0;
      st_empty <= 1'b1;
      st_full  <= 1'b0;
      rx_irq   <= 1'b0;
    end else if (cfg_wr) begin
      fifo_on <= cfg_fifo_on;
      if (flip) begin
        rptr     <= '0;
        cnt      <= '0;
        st_empty <= 1'b1;
        st_full  <= 1'b0;
      end
    end else begin
      cnt <= cnt_nxt;
      if (pop_ok) rptr <= rptr_inc;
      if (push_ok)                      st_empty <= 1'b0;
      else if (pop_ok && cnt == CW'(1)) st_empty <= 1'b1;
      if (push_ok && cnt_nxt == cap) st_full <= 1'b1;
      else if (rd_pop)               st_full <= 1'b0;
      if (push_ok && 32'(cnt_nxt) == 32'(trig))              rx_irq <= 1'b1;
      else if (pop_ok && 32'(cnt_pop) + 1 == 32'(trig))      rx_irq <= 1'b0;
    end
  end

  // R7
  full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_empty && st_full));

  // R6
  empty_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty == (cnt == '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cap);

  // R3
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (cnt == '0) && (rptr == '0));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && st_empty && !push_ok && !cfg_wr) |=> $stable(rptr) && st_empty);

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(push_ok));

  // R5
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_irq) |-> $past(pop_ok));
endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_fifo_on = 0, lvl_wr = 0, in_vld = 0, in_brk = 0, rd_pop = 0;
  logic [5:0] lvl_val = '0;
  logic [7:0] in_data = '0;
  logic [3:0] in_stat = '0;
  logic in_rdy, st_empty, st_full, rx_irq;
  logic [11:0] rd_entry;

  always #2.5 clk = ~clk;

  uart_rx_queue i_uart_rx_queue (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fifo_on(cfg_fifo_on),
    .lvl_wr(lvl_wr), .lvl_val(lvl_val), .in_vld(in_vld), .in_data(in_data),
    .in_stat(in_stat), .in_brk(in_brk), .in_rdy(in_rdy), .rd_pop(rd_pop),
    .rd_entry(rd_entry), .st_empty(st_empty), .st_full(st_full), .rx_irq(rx_irq));

  int checks = 0, fails = 0;
  bit done = 0;

  int q[$];
  bit m_en = 0, m_irq = 0, m_empty = 1, m_full = 0;
  int m_lvl = 'h12;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int cap = m_en ? 16 : 1;
    check("R2 in_rdy", in_rdy, q.size() < cap);
    check("R6 st_empty", st_empty, m_empty);
    check("R7 st_full", st_full, m_full);
    check("R5/R4 rx_irq", rx_irq, m_irq);
    if (q.size() > 0)
      check(q[0] == 'h400 ? "R8 rd_entry" : "R1 rd_entry", rd_entry, q[0]);
  endtask

  task automatic step(bit cw, bit ce, bit lw, int lv, bit pv, int pd, int ps, bit pb, bit pp);
    int cap, trig;
    bit rdy;
    cfg_wr = cw; cfg_fifo_on = ce; lvl_wr = lw; lvl_val = 6'(lv);
    in_vld = pv; in_data = 8'(pd); in_stat = 4'(ps); in_brk = pb; rd_pop = pp;
    cap = m_en ? 16 : 1;
    trig = (m_lvl >> 1) & 'h1C;
    rdy = q.size() < cap;
    if (cw) begin
      if (ce != m_en) begin q.delete(); m_empty = 1; m_full = 0; end
      m_en = ce;
    end else begin
      if (pp) begin
        m_full = 0;
        if (q.size() > 0) begin
          void'(q.pop_front());
          if (q.size() == trig - 1) m_irq = 0;
          if (q.size() == 0) m_empty = 1;
        end
      end
      if ((pv || pb) && rdy) begin
        q.push_back(pb ? 'h400 : ((ps & 'hF) << 8) | (pd & 'hFF));
        m_empty = 0;
        if (q.size() == cap) m_full = 1;
        if (q.size() == trig) m_irq = 1;
      end
    end
    if (lw) m_lvl = lv & 'h3F;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0; lvl_wr = 0; in_vld = 0; in_brk = 0; rd_pop = 0;
    compare();
  endtask

  task automatic push(int d, int s = 0); step(0,0,0,0, 1,d,s,0, 0); endtask
  task automatic pop();                  step(0,0,0,0, 0,0,0,0, 1); endtask
  task automatic brk();                  step(0,0,0,0, 0,0,0,1, 0); endtask
  task automatic cfg(bit e);             step(1,e,0,0, 0,0,0,0, 0); endtask
  task automatic setlvl(int v);          step(0,0,1,v, 0,0,0,0, 0); endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 empty", st_empty, 1);
    check("R10 full", st_full, 0);
    check("R10 irq", rx_irq, 0);
    check("R10 rdy", in_rdy, 1);
    compare();

    // single mode, R2 drop, R9 empty pop
    push('h41, 'h3);
    check("R7 single-mode full", st_full, 1);
    push('h42);
    check("R2 dropped offer", rd_entry, 'h341);
    pop();
    pop();
    check("R9 empty pop", st_empty, 1);
    push('h43);
    check("R9 next entry shown", rd_entry, 'h43);
    pop();

    // R3 mode change flush and same-mode write
    push('h44);
    cfg(1);
    check("R3 flush empty", st_empty, 1);
    push('h45); push('h46);
    cfg(1);
    check("R3 same mode keeps", rd_entry, 'h45);
    // R11 cfg write overrides offer and pop
    step(1,1,0,0, 1,'h99,0,0, 1);
    check("R11 pop ignored", rd_entry, 'h45);
    pop(); pop();

    // R5 threshold 8 fill to full with drops, then drain; R1 wrap
    for (int i = 0; i < 18; i++) push('h10 + i, i & 'hF);
    check("R7 queue full", st_full, 1);
    for (int i = 0; i < 16; i++) pop();
    // R4 threshold 4
    setlvl('h08);
    for (int i = 0; i < 6; i++) push('h60 + i);
    check("R4 irq at 4", rx_irq, 1);
    for (int i = 0; i < 6; i++) pop();
    // R4 threshold 28 unreachable
    setlvl('h3F);
    for (int i = 0; i < 16; i++) push('h70 + i);
    check("R4 no irq at 28", rx_irq, 0);
    // simultaneous pop and offer when full
    step(0,0,0,0, 1,'hAA,0,0, 1);
    step(0,0,0,0, 1,'hAB,0,0, 1);
    for (int i = 0; i < 16; i++) pop();
    // R8 break with data offer
    setlvl('h00);
    brk();
    step(0,0,0,0, 1,'h55,0,1, 0);
    push('h56);
    check("R8 break entry", rd_entry, 'h400);
    pop(); pop(); pop();
    // flush back to single mode with content
    push(1); push(2);
    cfg(0);
    check("R3 flush to single", st_empty, 1);
    cfg(1);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom;
      if (r % 97 == 0) step(1, (r >> 8) & 1, 0, 0, 0,0,0,0, 0);
      else if (r % 53 == 0) step(0,0,1, (r >> 8) & 'h3F, 0,0,0,0, 0);
      else step(0,0,0,0, (r >> 2) & 1, (r >> 4) & 'hFF, (r >> 12) & 'hF,
                (r % 41) == 0, ((r >> 3) & 3) == 0 ? ((r >> 16) & 1) : ((r >> 17) & 1) & ((r >> 18) & 1));
    end
    for (int i = 0; i < 20; i++) pop();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule